// File: doc/BRIEF.md
# Reloadable Millisecond Interval Timer

This block is a periodic interval timer whose period is set by a bus-written reload value. It counts pulses of an externally generated 1 kHz tick enable, which is one system-clock cycle wide. When `reload + 1` ticks have been counted since the period began, the timer raises its interrupt. It then begins the next period by itself.

Software controls the timer with two strobes. A reload write stores a new value, drops the interrupt and starts a fresh full period. A count read acknowledges the interrupt, and the data it returns is always zero. The interrupt is a level that stays high from an expiry until one of these two accesses clears it.

Top module: `ms_interval_timer`

## Requirements
- R1: After a period starts, `irq_o` rises in the cycle after the system-clock edge that samples the (L+1)-th `tick_1k_i` pulse, where L is the stored period limit. It does not rise before that pulse.
- R2: When `reload_wr_i` is sampled high, the block stores the value and drives `irq_o` low in the next cycle. Counting restarts from zero. A tick pulse in that same cycle is not counted.
- R3: An expiry starts the next period at once, with no software action. The next expiry follows after another L+1 ticks.
- R4: When `count_rd_i` is sampled high with no expiry in the same cycle, `irq_o` is low in the next cycle. `count_rdata_o` reads as 32'h0000_0000.
- R5: Synchronous active-high reset sets the period limit to 0, clears the tick count and drives `irq_o` low.
- R6: If an acknowledge read and an expiry are sampled at the same edge, the expiry wins and `irq_o` is high afterwards.
- R7: Only bits [15:0] of `reload_wdata_i` set L. Bits [31:16] are ignored. For example, writing 32'hABCD_0001 gives a two-tick period.
- R8: `irq_o` changes only on an expiry, a reload write, an acknowledge read or reset. Cycles without ticks or accesses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k_i | input | 1 | One-cycle 1 kHz tick enable |
| reload_wr_i | input | 1 | Reload register write strobe |
| reload_wdata_i | input | 32 | Reload write data; only the low 16 bits are used |
| count_rd_i | input | 1 | Count register read strobe (acknowledge) |
| count_rdata_o | output | 32 | Count register read data, always zero |
| irq_o | output | 1 | Interval interrupt, level |

## Verification
A wrong tick count or a stale period limit makes the interrupt appear one or more ticks early or late. A reference model compares the interrupt every cycle, so the error shows up at the first expiry after the fault, within L+1 ticks. A lost restart or acknowledge leaves `irq_o` high in the cycle just after the access, so that fault is reported on the next clock. The same-edge cases are all driven on purpose: write against tick, and read against expiry.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int DATA_W   = 32;
    localparam int PERIOD_W = 16;

    typedef logic [PERIOD_W-1:0] period_t;

    // Events seen by the period counter and the interrupt flag in one cycle
    typedef struct packed {
        logic restart;
        logic tick;
        logic ack;
    } tmr_evt_t;

    localparam logic [DATA_W-1:0] COUNT_READ_VALUE = '0;

    function automatic period_t limit_of(input logic [DATA_W-1:0] wdata);
        return wdata[PERIOD_W-1:0];
    endfunction
endpackage

// File: rtl/ivt_reload_reg.sv
module ivt_reload_reg
    import ivt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output period_t       limit_o
);
    // Upper bits are discarded at the write; only the period field is kept
    always_ff @(posedge clk) begin
        if (rst)       limit_o <= '0;
        else if (wr_i) limit_o <= limit_of(wdata_i);
    end
endmodule

// File: rtl/ivt_period_cnt.sv
module ivt_period_cnt
    import ivt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_evt_t evt_i,
    input  period_t  limit_i,
    output logic     expire_o
);
    period_t cnt_q;

    assign expire_o = evt_i.tick && !evt_i.restart && (cnt_q == limit_i);

    always_ff @(posedge clk) begin
        if (rst || evt_i.restart) cnt_q <= '0;
        else if (expire_o)        cnt_q <= '0;
        else if (evt_i.tick)      cnt_q <= cnt_q + 1'b1;
    end

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.restart |=> (cnt_q == '0));
    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit_i);
endmodule

// File: rtl/ivt_irq_flag.sv
module ivt_irq_flag
    import ivt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_evt_t evt_i,
    input  logic     expire_i,
    output logic     irq_o
);
    always_ff @(posedge clk) begin
        if (rst)                               irq_o <= 1'b0;
        else if (expire_i)                     irq_o <= 1'b1;
        else if (evt_i.restart || evt_i.ack)   irq_o <= 1'b0;
    end

    // R6
    expire_wins_chk: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> irq_o);
    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.ack && !expire_i) |=> !irq_o);
    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!expire_i && !evt_i.restart && !evt_i.ack) |=> $stable(irq_o));
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer
    import ivt_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_1k_i,
    input  logic          reload_wr_i,
    input  logic [DW-1:0] reload_wdata_i,
    input  logic          count_rd_i,
    output logic [DW-1:0] count_rdata_o,
    output logic          irq_o
);
    tmr_evt_t evt;
    period_t  limit;
    logic     expire;

    assign evt.restart   = reload_wr_i;
    assign evt.tick      = tick_1k_i;
    assign evt.ack       = count_rd_i;
    assign count_rdata_o = DW'(COUNT_READ_VALUE);

    ivt_reload_reg #(.DW(DW)) u_reload (
        .clk(clk), .rst(rst), .wr_i(reload_wr_i),
        .wdata_i(reload_wdata_i), .limit_o(limit)
    );

    ivt_period_cnt u_cnt (
        .clk(clk), .rst(rst), .evt_i(evt), .limit_i(limit), .expire_o(expire)
    );

    ivt_irq_flag u_irq (
        .clk(clk), .rst(rst), .evt_i(evt), .expire_i(expire), .irq_o(irq_o)
    );

    // R2
    write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        reload_wr_i |=> !irq_o);
    // R5
    reset_low_chk: assert property (@(posedge clk)
        rst |=> !irq_o);
    // R7
    limit_low_bits_chk: assert property (@(posedge clk) disable iff (rst)
        reload_wr_i |=> (limit == $past(reload_wdata_i[PERIOD_W-1:0])));
endmodule

// File: tb/ms_interval_timer_tb.sv
module ms_interval_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // model state
    int unsigned m_lim = 0;
    int unsigned m_cnt = 0;
    bit          m_irq = 0;

    always #2 clk = ~clk;   // 250 MHz

    ms_interval_timer dut_i (
        .clk(clk), .rst(rst), .tick_1k_i(tick), .reload_wr_i(wr),
        .reload_wdata_i(wdata), .count_rd_i(rd), .count_rdata_o(rdata), .irq_o(irq)
    );

    task automatic cyc(input bit r, input bit t, input bit w,
                       input logic [31:0] d, input bit a, input string tag);
        bit exp_now;
        rst = r; tick = t; wr = w; wdata = d; rd = a;
        @(posedge clk);
        if (r) begin
            m_lim = 0; m_cnt = 0; m_irq = 0;
        end else if (w) begin
            m_lim = d & 32'hFFFF; m_cnt = 0; m_irq = 0;
        end else begin
            exp_now = 0;
            if (t) begin
                if (m_cnt == m_lim) begin exp_now = 1; m_cnt = 0; end
                else m_cnt++;
            end
            if (exp_now) m_irq = 1;
            else if (a) m_irq = 0;
        end
        @(negedge clk);
        compared++;
        if (irq !== m_irq) begin
            mismatched++;
            $display("FAIL %s irq got %0b expected %0b at %0t", tag, irq, m_irq, $time);
        end
        if (a) begin
            compared++;
            if (rdata !== 32'h0) begin
                mismatched++;
                $display("FAIL R4 rdata got %h expected %h", rdata, 32'h0);
            end
        end
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, "R5");
        // R1/R3: limit 2, a tick every third cycle, occasional acknowledge
        cyc(0, 0, 1, 32'd2, 0, "R2");
        for (int i = 0; i < 90; i++) cyc(0, (i % 3) == 0, 0, 0, (i % 17) == 9, "R1_R3");
        // R8: idle cycles leave the level alone
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 0, "R8");
        // R4: acknowledge with no expiry
        cyc(0, 0, 0, 0, 1, "R4");
        cyc(0, 0, 0, 0, 1, "R4");
        // R6: limit 0 expires on every tick; read at the same edge
        cyc(0, 0, 1, 32'd0, 0, "R2");
        cyc(0, 1, 0, 0, 1, "R6");
        cyc(0, 0, 0, 0, 0, "R6");
        cyc(0, 1, 0, 0, 1, "R6");
        // R2: write while the interrupt is high, and write together with a tick
        cyc(0, 1, 0, 0, 0, "R2");
        cyc(0, 1, 1, 32'd1, 0, "R2");
        for (int i = 0; i < 8; i++) cyc(0, (i % 2) == 0, 0, 0, 0, "R2");
        // R7: upper bits ignored, period of two ticks
        cyc(0, 0, 1, 32'hABCD_0001, 0, "R7");
        for (int i = 0; i < 24; i++) cyc(0, (i % 3) == 1, 0, 0, (i % 7) == 3, "R7");
        // R5: reset in the middle of a period
        cyc(0, 0, 1, 32'd5, 0, "R5");
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 0, "R5");
        cyc(1, 1, 0, 0, 0, "R5");
        for (int i = 0; i < 6; i++) cyc(0, (i % 2) == 0, 0, 0, 0, "R5");
        // R1: longer limit
        cyc(0, 0, 1, 32'd20, 0, "R1");
        for (int i = 0; i < 80; i++) cyc(0, (i % 2) == 1, 0, 0, (i % 29) == 28, "R1");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule